// File: doc/BRIEF.md
# Reduced UART Register Slave with Host-Fed Receive Queue

This block is a memory-mapped register slave that offers a processor a cut-down version of a familiar UART programming model. No serial line is involved. Bytes for the processor arrive on a host push port and wait in a receive FIFO. Bytes that the processor writes come out on a transmit byte stream that is always ready. An interrupt line goes high when bytes arrive and drops when software drains the FIFO.

The receive status bits are not stored latches. They are derived from FIFO occupancy, so software clears the receive condition by reading data rather than by writing the clear register. The divisor, line-control and control registers accept writes and discard them, so an existing driver can run its usual setup sequence. Constant identification words let that driver recognise the device.

A parameter sets the FIFO depth. A sticky overflow output records any byte dropped at a full FIFO. A synchronous flush input empties the FIFO and reports how many bytes it threw away.

Top module: `uart_lite_regs`

## Requirements
- R1: Register offsets, as 12-bit byte addresses, are:
  - data 0x000
  - flags 0x018
  - divisors 0x024 and 0x028
  - line control 0x02C
  - control 0x030
  - interrupt mask 0x038
  - raw status 0x03C
  - masked status 0x040
  - interrupt clear 0x044
  - identification words at 0xFE0 to 0xFFC in steps of 4

  The identification words read, in ascending address order, 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1. Unmapped offsets read 0. `bus_rdata` is loaded on the clock edge that samples `bus_rd` and holds until the next read.
- R2: A data read pops the oldest receive byte into bits [7:0], and bits [31:8] read 0. A data read while the FIFO is empty returns 0.
- R3: In the flag register, bit 7 always reads 1 and bit 4 reads 1 exactly when the receive FIFO is empty. All other bits read 0, so an empty device reads 0x90.
- R4: Raw status bit 4 reads 1 while the FIFO holds at least one byte, and all its other bits read 0. Masked status equals raw status AND mask. The mask register stores and returns the full 32-bit word written to it.
- R5: A write to the interrupt clear register changes nothing: a pending byte stays readable and raw status stays set.
- R6: Every host push raises `irq` on the next edge. `irq` falls when a data read leaves the FIFO empty, whatever the mask holds. A push in the same cycle as the read of the last byte keeps `irq` high and keeps the pushed byte.
- R7: A data write raises `tx_valid` for exactly one cycle after the write edge, with `tx_byte` equal to write data [7:0]. Writes to the divisor, line-control and control registers are dropped, and those registers read 0.
- R8: Bytes leave the FIFO in push order.
- R9: The FIFO holds DEPTH bytes (default 16). A push to a full FIFO is dropped and sets the sticky `rx_overflow` output. A push to a full FIFO in the same cycle as a data read is accepted.
- R10: `flush` empties the FIFO and drops `irq` on the next edge, and loads `flush_count` with the number of bytes discarded. A flush overrides a push and a data read in the same cycle: the pushed byte is lost, is not counted, and the read returns 0.
- R11: After reset, `bus_rdata`, `tx_valid`, `irq`, `rx_overflow`, `flush_count` and the mask register are 0, and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (12) | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| host_push | input | 1 | Push one byte into the receive FIFO |
| host_byte | input | 8 | Byte to push |
| flush | input | 1 | Empty the receive FIFO |
| tx_byte | output | 8 | Transmitted byte |
| tx_valid | output | 1 | One-cycle strobe for tx_byte |
| irq | output | 1 | Level receive interrupt |
| rx_overflow | output | 1 | Sticky flag: a push was dropped |
| flush_count | output | $clog2(DEPTH+1) | Bytes discarded by the last flush |

## Verification
Two pairs of events can fall in the same cycle, and the bench drives each pair together from one negative clock edge.

The first pair is a host push and the data read that removes the last stored byte. The bench expects the old byte on the bus, `irq` still high, and the new byte on the following read.

The second pair is a flush arriving together with both a push and a data read. The bench expects a zero read value, a discard count that leaves out the pushed byte, an empty flag pattern and a low `irq`. A full-FIFO push that coincides with a pop is judged by draining all DEPTH bytes and confirming that `rx_overflow` stayed low.

// File: rtl/uart_lite_pkg.sv
package uart_lite_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFF_DATA  = 12'h000;
  localparam logic [ADDR_W-1:0] OFF_FLAGS = 12'h018;
  localparam logic [ADDR_W-1:0] OFF_MASK  = 12'h038;
  localparam logic [ADDR_W-1:0] OFF_RAW   = 12'h03C;
  localparam logic [ADDR_W-1:0] OFF_MSKD  = 12'h040;
  localparam logic [ADDR_W-1:0] OFF_CLR   = 12'h044;

  localparam int RX_BIT    = 4;
  localparam int TXE_BIT   = 7;
  localparam int EMPTY_BIT = 4;

  function automatic logic [7:0] ident_word(input logic [2:0] idx);
    case (idx)
      3'd0: ident_word = 8'h11;
      3'd1: ident_word = 8'h10;
      3'd2: ident_word = 8'h14;
      3'd3: ident_word = 8'h00;
      3'd4: ident_word = 8'h0D;
      3'd5: ident_word = 8'hF0;
      3'd6: ident_word = 8'h05;
      default: ident_word = 8'hB1;
    endcase
  endfunction
endpackage

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  input  logic                         flush,
  output logic [DW-1:0]                head,
  output logic                         empty,
  output logic                         full,
  output logic                         accepted,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop_eff;

  assign empty    = (level == '0);
  assign full     = (level == LW'(DEPTH));
  assign pop_eff  = pop && !empty && !flush;
  assign accepted = push && !flush && (!full || pop_eff);
  assign head     = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (accepted) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (accepted) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_eff)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      level <= level + LW'(accepted) - LW'(pop_eff);
      if (push && !accepted) overflow <= 1'b1;
    end
  end

  // R9
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R9
  drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !flush) |=> (full && overflow));
endmodule

// File: rtl/uart_lite_irq.sv
module uart_lite_irq (
  input  logic clk,
  input  logic rst,
  input  logic raise,
  input  logic drained,
  input  logic flush,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (rst)          irq_q <= 1'b0;
    else if (flush)   irq_q <= 1'b0;
    else if (raise)   irq_q <= 1'b1;
    else if (drained) irq_q <= 1'b0;
  end

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> !irq_q);
  // R6
  push_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (raise && !flush) |=> irq_q);
endmodule

// File: rtl/uart_lite_regs.sv
module uart_lite_regs
  import uart_lite_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              host_push,
  input  logic [7:0]        host_byte,
  input  logic              flush,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  output logic              irq,
  output logic              rx_overflow,
  output logic [CW-1:0]     flush_count
);
  logic [7:0]    rx_head;
  logic          rx_empty, rx_full, rx_accepted;
  logic [CW-1:0] rx_level;
  logic [31:0]   mask_q;
  logic          data_pop, last_drain;
  logic [31:0]   raw_stat, rd_val;

  assign data_pop   = bus_rd && (bus_addr == OFF_DATA) && !rx_empty && !flush;
  assign last_drain = data_pop && (rx_level == CW'(1)) && !rx_accepted;
  assign raw_stat   = {{(31-RX_BIT){1'b0}}, !rx_empty, {RX_BIT{1'b0}}};

  rx_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_fifo (
    .clk(clk), .rst(rst),
    .push(host_push), .push_data(host_byte),
    .pop(data_pop), .flush(flush),
    .head(rx_head), .empty(rx_empty), .full(rx_full),
    .accepted(rx_accepted), .level(rx_level), .overflow(rx_overflow)
  );

  uart_lite_irq u_irq (
    .clk(clk), .rst(rst),
    .raise(host_push), .drained(last_drain), .flush(flush),
    .irq_q(irq)
  );

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      OFF_DATA:  rd_val = data_pop ? {24'h0, rx_head} : 32'h0;
      OFF_FLAGS: begin
        rd_val[TXE_BIT]   = 1'b1;
        rd_val[EMPTY_BIT] = rx_empty;
      end
      OFF_MASK:  rd_val = mask_q;
      OFF_RAW:   rd_val = raw_stat;
      OFF_MSKD:  rd_val = raw_stat & mask_q;
      default: begin
        if (bus_addr[ADDR_W-1:5] == '1 && bus_addr[1:0] == 2'b00)
          rd_val = {24'h0, ident_word(bus_addr[4:2])};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata   <= '0;
      mask_q      <= '0;
      tx_byte     <= '0;
      tx_valid    <= 1'b0;
      flush_count <= '0;
    end else begin
      tx_valid <= bus_wr && (bus_addr == OFF_DATA);
      if (bus_wr && bus_addr == OFF_DATA) tx_byte <= bus_wdata[7:0];
      if (bus_wr && bus_addr == OFF_MASK) mask_q <= bus_wdata;
      if (bus_rd) bus_rdata <= rd_val;
      if (flush) flush_count <= rx_level;
    end
  end

  // R6
  irq_matches_fifo_chk: assert property (@(posedge clk) disable iff (rst)
    irq == !rx_empty);
  // R7
  tx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_DATA) |=> (tx_valid && tx_byte == $past(bus_wdata[7:0])));
  // R5
  clr_noop_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_CLR && !bus_rd && !host_push && !flush) |=> $stable(rx_level));
  // R10
  flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> (rx_level == '0));
endmodule

// File: tb/uart_lite_regs_bench.sv
module uart_lite_regs_bench;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH+1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic host_push = 1'b0;
  logic [7:0] host_byte = '0;
  logic flush = 1'b0;
  logic [7:0] tx_byte;
  logic tx_valid, irq, rx_overflow;
  logic [CW-1:0] flush_count;

  int checks = 0;
  int errors = 0;
  logic [31:0] rv;

  always #10 clk = ~clk;

  uart_lite_regs #(.DEPTH(DEPTH)) u_uart_lite_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .host_push(host_push),
    .host_byte(host_byte), .flush(flush), .tx_byte(tx_byte), .tx_valid(tx_valid),
    .irq(irq), .rx_overflow(rx_overflow), .flush_count(flush_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic do_push(input logic [7:0] b);
    @(negedge clk); host_byte = b; host_push = 1'b1;
    @(negedge clk); host_push = 1'b0;
  endtask

  task automatic t_reset;
    check("R11 rdata", bus_rdata, 0);
    check("R11 irq", {31'h0, irq}, 0);
    check("R11 tx_valid", {31'h0, tx_valid}, 0);
    check("R11 overflow", {31'h0, rx_overflow}, 0);
    check("R11 flush_count", 32'(flush_count), 0);
    do_read(12'h038, rv); check("R11 mask", rv, 0);
  endtask

  task automatic t_ids;
    logic [7:0] exp_ids [8] = '{8'h11, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    for (int i = 0; i < 8; i++) begin
      do_read(12'hFE0 + 12'(4*i), rv); check("R1 ident", rv, 32'(exp_ids[i]));
    end
    do_read(12'h100, rv); check("R1 unmapped", rv, 0);
  endtask

  task automatic t_empty;
    do_read(12'h018, rv); check("R3 flags empty", rv, 32'h90);
    do_read(12'h000, rv); check("R2 empty data", rv, 0);
    do_read(12'h03C, rv); check("R4 raw empty", rv, 0);
  endtask

  task automatic t_order;
    do_push(8'hA1); do_push(8'hB2); do_push(8'hC3);
    do_read(12'h018, rv); check("R3 flags nonempty", rv, 32'h80);
    do_read(12'h000, rv); check("R8 first", rv, 32'hA1);
    do_read(12'h000, rv); check("R8 second", rv, 32'hB2);
    do_read(12'h000, rv); check("R8 third", rv, 32'hC3);
    do_read(12'h000, rv); check("R2 drained", rv, 0);
  endtask

  task automatic t_status_mask;
    do_write(12'h038, 32'hDEAD_BEEF);
    do_read(12'h038, rv); check("R4 mask readback", rv, 32'hDEAD_BEEF);
    do_write(12'h038, 32'h0);
    do_push(8'h41);
    do_read(12'h03C, rv); check("R4 raw set", rv, 32'h10);
    do_read(12'h040, rv); check("R4 masked off", rv, 0);
    check("R6 irq mask-independent", {31'h0, irq}, 1);
    do_write(12'h038, 32'h10);
    do_read(12'h040, rv); check("R4 masked on", rv, 32'h10);
    do_write(12'h044, 32'hFFFF_FFFF);
    do_read(12'h03C, rv); check("R5 raw after clear", rv, 32'h10);
    do_read(12'h000, rv); check("R5 byte after clear", rv, 32'h41);
    check("R6 irq low after drain", {31'h0, irq}, 0);
    do_read(12'h040, rv); check("R4 masked drained", rv, 0);
  endtask

  task automatic t_tx;
    @(negedge clk); bus_addr = 12'h000; bus_wdata = 32'h1234_567E; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    check("R7 tx_valid", {31'h0, tx_valid}, 1);
    check("R7 tx_byte", {24'h0, tx_byte}, 32'h7E);
    @(negedge clk);
    check("R7 tx pulse ends", {31'h0, tx_valid}, 0);
    do_write(12'h024, 32'h55); do_write(12'h028, 32'h55);
    do_write(12'h02C, 32'h55); do_write(12'h030, 32'h55);
    do_read(12'h024, rv); check("R7 divisor ignored", rv, 0);
    do_read(12'h030, rv); check("R7 control ignored", rv, 0);
    do_read(12'h018, rv); check("R7 flags untouched", rv, 32'h90);
  endtask

  task automatic t_push_last_pop;
    do_push(8'h55);
    @(negedge clk); bus_addr = 12'h000; bus_rd = 1'b1; host_push = 1'b1; host_byte = 8'h66;
    @(negedge clk); bus_rd = 1'b0; host_push = 1'b0;
    check("R6 same-cycle read", bus_rdata, 32'h55);
    check("R6 irq held", {31'h0, irq}, 1);
    do_read(12'h000, rv); check("R6 pushed byte kept", rv, 32'h66);
    check("R6 irq dropped", {31'h0, irq}, 0);
  endtask

  task automatic t_full_push_pop;
    for (int i = 0; i < DEPTH; i++) do_push(8'h20 + 8'(i));
    @(negedge clk); bus_addr = 12'h000; bus_rd = 1'b1; host_push = 1'b1; host_byte = 8'hEE;
    @(negedge clk); bus_rd = 1'b0; host_push = 1'b0;
    check("R9 full pop value", bus_rdata, 32'h20);
    check("R9 no overflow", {31'h0, rx_overflow}, 0);
    for (int i = 1; i < DEPTH; i++) begin
      do_read(12'h000, rv); check("R9 drain order", rv, 32'h20 + 32'(i));
    end
    do_read(12'h000, rv); check("R9 accepted at full", rv, 32'hEE);
    do_read(12'h018, rv); check("R9 empty after", rv, 32'h90);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < DEPTH; i++) do_push(8'h40 + 8'(i));
    check("R9 full no overflow", {31'h0, rx_overflow}, 0);
    do_push(8'h99);
    check("R9 overflow set", {31'h0, rx_overflow}, 1);
    for (int i = 0; i < DEPTH; i++) begin
      do_read(12'h000, rv); check("R9 overflow order", rv, 32'h40 + 32'(i));
    end
    do_read(12'h000, rv); check("R9 dropped byte", rv, 0);
    check("R9 overflow sticky", {31'h0, rx_overflow}, 1);
  endtask

  task automatic t_flush;
    do_push(8'h01); do_push(8'h02); do_push(8'h03);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    check("R10 count", 32'(flush_count), 3);
    check("R10 irq", {31'h0, irq}, 0);
    do_read(12'h018, rv); check("R10 flags", rv, 32'h90);
    do_push(8'h0A); do_push(8'h0B);
    @(negedge clk); flush = 1'b1; host_push = 1'b1; host_byte = 8'h0C;
    bus_addr = 12'h000; bus_rd = 1'b1;
    @(negedge clk); flush = 1'b0; host_push = 1'b0; bus_rd = 1'b0;
    check("R10 read during flush", bus_rdata, 0);
    check("R10 count excludes push", 32'(flush_count), 2);
    check("R10 irq after race", {31'h0, irq}, 0);
    do_read(12'h000, rv); check("R10 push lost", rv, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ids();
    t_empty();
    t_order();
    t_status_mask();
    t_tx();
    t_push_last_pop();
    t_full_push_pop();
    t_overflow();
    t_flush();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule